// File: doc/BRIEF.md
# Dual-Mode Pipeline Stage Register Controller

This block is one stage of a valid/ready pipeline. It holds one data word and decides when its stage register is enabled. There are two idle policies, chosen at run time by a single mode input.

In the open-idle policy the register stays enabled whenever the stage is empty. Whatever sits on the input bus flows to the output one clock later, so an arriving item is captured without delay. In the shut-idle policy the register stays disabled while the stage is empty. When an item shows up, the stage first spends one cycle opening. It then captures the whole word in one update, so stale or changing input bits never reach the next stage. The cost is one extra cycle of latency per item that arrives at an empty stage. When the stage is full and the consumer drains it in the same cycle that a new item arrives, both policies behave identically.

A requested policy change is first registered as pending. It is applied only while the stage is empty, not opening, and the input is idle. An activity counter counts every cycle in which the register enable differs from its value in the cycle before, so the switching cost of the two policies can be compared.

Top module: `dualModeStage`

## Requirements
- R1: While rstN is low at a clock edge the stage becomes empty with policy open-idle. After reset, outValid=0, inReady=1, modeNow=0, dataOut=0 and actCount=0.
- R2: In open-idle policy (modeNow=0), an item accepted at a clock edge (inValid=1 and inReady=1) appears on dataOut with outValid=1 right after that same edge.
- R3: In open-idle policy with the stage empty, dataOut takes the value inData had at each clock edge, even when inValid is low.
- R4: In shut-idle policy (modeNow=1) with the stage empty and inValid low, dataOut keeps its value whatever inData does, and inReady is 0.
- R5: In shut-idle policy, when inValid rises at an empty stage, inReady rises after the next edge and the item is captured at the edge after that. outValid is therefore 1 two edges after inValid was first seen.
- R6: When the stage is full, inReady equals outReady in both policies. With outReady held high, a stream of N items needs N+1 edges in open-idle policy and N+2 edges in shut-idle policy. Items leave in arrival order with no loss.
- R7: While outValid=1 and outReady=0, outValid stays 1 and dataOut stays unchanged, whatever inData does.
- R8: modeReq is registered once at every clock edge. The registered request becomes modeNow at the first later edge at which the stage is empty, not opening, and inValid is low. modeNow never changes at an edge where outValid or inValid was 1.
- R9: At every edge, actCount increases by exactly 1 if the register enable in the cycle before that edge differs from the enable in the cycle before it; otherwise it holds. The counter wraps at its width. One isolated item in shut-idle policy adds 2. Idling in either policy adds 0. Switching from open-idle to shut-idle while empty adds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeReq | input | 1 | Requested idle policy: 0 open-idle, 1 shut-idle |
| inValid | input | 1 | Upstream item valid |
| inReady | output | 1 | Stage can accept an item this cycle |
| inData | input | DATA_W | Upstream data word |
| outValid | output | 1 | Stage holds an item |
| outReady | input | 1 | Downstream accepts the held item |
| dataOut | output | DATA_W | Stage register contents |
| modeNow | output | 1 | Policy currently applied |
| actCount | output | CNT_W | Count of register enable transitions |

## Verification
The bench streams sequences through both policies under three consumer back-pressure patterns and compares each departing word, in order, against a value it computes arithmetically. With no back-pressure it also counts edges, so a shut-idle stage that re-opened between back-to-back items would show up as missing throughput. Policy requests are made both while the stage is idle and while it is full. A controller that switched in the middle of a transfer would change modeNow too early. The bench also measures the counter delta across an isolated shut-idle transfer, across idle stretches and across a policy switch. A counter that counted enabled cycles instead of transitions would report the wrong delta.

// File: rtl/dualModeStagePkg.sv
package dualModeStagePkg;

  typedef enum logic {
    MODE_OPEN = 1'b0,
    MODE_SHUT = 1'b1
  } idleMode_t;

  typedef struct packed {
    logic regEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/stageCtrl.sv
module stageCtrl
  import dualModeStagePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeReq,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output logic        modeNow,
  output ctrlStrobe_t strobe
);

  logic      fullQ;
  logic      openingQ;
  idleMode_t activeQ;
  idleMode_t pendQ;

  logic accept;
  logic drain;
  logic safePoint;

  always_comb begin
    if (activeQ == MODE_OPEN) begin
      inReady = !fullQ || outReady;
    end else begin
      inReady = fullQ ? outReady : openingQ;
    end
  end

  assign accept    = inValid && inReady;
  assign drain     = fullQ && outReady;
  assign safePoint = !fullQ && !openingQ && !inValid;

  always_comb begin
    if (activeQ == MODE_OPEN) begin
      strobe.regEn = !fullQ || accept;
    end else begin
      strobe.regEn = accept;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullQ    <= 1'b0;
      openingQ <= 1'b0;
      activeQ  <= MODE_OPEN;
      pendQ    <= MODE_OPEN;
    end else begin
      pendQ <= idleMode_t'(modeReq);
      if (accept) begin
        fullQ <= 1'b1;
      end else if (drain) begin
        fullQ <= 1'b0;
      end
      if (openingQ) begin
        openingQ <= !accept;
      end else begin
        openingQ <= (activeQ == MODE_SHUT) && !fullQ && inValid;
      end
      if (safePoint) begin
        activeQ <= pendQ;
      end
    end
  end

  assign outValid = fullQ;
  assign modeNow  = (activeQ == MODE_SHUT);

endmodule

// File: rtl/stageData.sv
module stageData
  import dualModeStagePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] dataOut
);

  logic [DATA_W-1:0] wordQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (strobe.regEn) begin
      wordQ <= inData;
    end
  end

  assign dataOut = wordQ;

endmodule

// File: rtl/toggleCounter.sv
module toggleCounter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enNow,
  output logic [CNT_W-1:0] count
);

  logic             prevEn;
  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevEn <= 1'b1;
      countQ <= '0;
    end else begin
      prevEn <= enNow;
      if (enNow != prevEn) begin
        countQ <= countQ + 1'b1;
      end
    end
  end

  assign count = countQ;

endmodule

// File: rtl/dualModeStage.sv
module dualModeStage
  import dualModeStagePkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeReq,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] dataOut,
  output logic              modeNow,
  output logic [CNT_W-1:0]  actCount
);

  ctrlStrobe_t strobe;

  stageCtrl ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeReq  (modeReq),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .modeNow  (modeNow),
    .strobe   (strobe)
  );

  stageData #(.DATA_W(DATA_W)) dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inData),
    .dataOut (dataOut)
  );

  toggleCounter #(.CNT_W(CNT_W)) activity (
    .clk   (clk),
    .rstN  (rstN),
    .enNow (strobe.regEn),
    .count (actCount)
  );

endmodule

// File: rtl/stageChecker.sv
module stageChecker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic              modeNow,
  input logic [DATA_W-1:0] dataOut,
  input logic [CNT_W-1:0]  actCount
);

  // R2
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R6
  full_drain_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |-> inReady);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(dataOut)));

  // R4
  shut_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow && !outValid && !inValid) |=> $stable(dataOut));

  // R8
  mode_busy_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> $stable(modeNow));

  // R8
  mode_busy_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> $stable(modeNow));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actCount != $past(actCount)) |-> (actCount == CNT_W'($past(actCount) + 1'b1)));

endmodule

bind dualModeStage stageChecker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .modeNow  (modeNow),
  .dataOut  (dataOut),
  .actCount (actCount)
);

// File: tb/dualModeStage_test.sv
module dualModeStage_test;

  localparam int DATA_W = 8;
  localparam int CNT_W  = 16;
  localparam int N      = 20;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              modeReq = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [DATA_W-1:0] inData = '0;
  logic              outValid;
  logic              outReady = 1'b0;
  logic [DATA_W-1:0] dataOut;
  logic              modeNow;
  logic [CNT_W-1:0]  actCount;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dualModeStage #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .modeReq(modeReq), .inValid(inValid),
    .inReady(inReady), .inData(inData), .outValid(outValid),
    .outReady(outReady), .dataOut(dataOut), .modeNow(modeNow),
    .actCount(actCount)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] seqVal(input int k, input int m, input int p);
    return DATA_W'((k * 37 + m * 11 + p * 3 + 5) % 256);
  endfunction

  task automatic setMode(input logic m);
    modeReq  = m;
    inValid  = 1'b0;
    outReady = 1'b1;
    repeat (4) tick();
    chk(modeNow == m, "R8 idle switch", modeNow, m);
  endtask

  task automatic stream(input int m, input int p);
    int sent = 0;
    int recv = 0;
    int cyc  = 0;
    while (recv < N && cyc < 400) begin
      case (p)
        0: outReady = 1'b1;
        1: outReady = (cyc % 2 == 0);
        default: outReady = (cyc % 3 != 0);
      endcase
      inValid = (sent < N);
      inData  = seqVal(sent, m, p);
      #1;
      if (outValid && outReady) begin
        chk(dataOut == seqVal(recv, m, p), "R6 stream order", dataOut, seqVal(recv, m, p));
        recv++;
      end
      if (inValid && inReady) sent++;
      tick();
      cyc++;
    end
    inValid = 1'b0;
    chk(recv == N, "R6 stream count", recv, N);
    if (p == 0) begin
      chk(cyc == N + 1 + m, "R6 full-rate edges", cyc, N + 1 + m);
    end
  endtask

  initial begin
    int base;
    logic [DATA_W-1:0] held;
    repeat (3) tick();
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(outValid == 1'b0, "R1 outValid", outValid, 0);
    chk(inReady == 1'b1, "R1 inReady", inReady, 1);
    chk(modeNow == 1'b0, "R1 modeNow", modeNow, 0);
    chk(dataOut == '0, "R1 dataOut", dataOut, 0);
    chk(actCount == '0, "R1 actCount", actCount, 0);

    // R2 open-idle capture latency
    inData = 8'h3C; inValid = 1'b1; outReady = 1'b0;
    tick();
    inValid = 1'b0;
    chk(outValid == 1'b1, "R2 outValid", outValid, 1);
    chk(dataOut == 8'h3C, "R2 dataOut", dataOut, 8'h3C);
    // R7 stall hold
    inData = 8'hA5;
    tick();
    chk(outValid == 1'b1, "R7 outValid", outValid, 1);
    chk(dataOut == 8'h3C, "R7 dataOut", dataOut, 8'h3C);
    chk(inReady == outReady, "R6 inReady full", inReady, outReady);
    outReady = 1'b1;
    tick();
    chk(outValid == 1'b0, "R2 drained", outValid, 0);
    // R3 open-idle tracking
    base = int'(actCount);
    for (int k = 0; k < 4; k++) begin
      inData = DATA_W'(8'h51 + k * 19);
      tick();
      chk(dataOut == DATA_W'(8'h51 + k * 19), "R3 track", dataOut, 8'h51 + k * 19);
    end
    tick();
    chk(int'(actCount) == base + 1, "R9 open idle", actCount, base + 1);

    // R8 switch to shut-idle while idle: two edges
    base = int'(actCount);
    modeReq = 1'b1;
    tick();
    chk(modeNow == 1'b0, "R8 not yet", modeNow, 0);
    tick();
    chk(modeNow == 1'b1, "R8 applied", modeNow, 1);
    tick();
    chk(int'(actCount) == base + 1, "R9 switch", actCount, base + 1);

    // R4 shut idle hold
    held = dataOut;
    base = int'(actCount);
    for (int k = 0; k < 3; k++) begin
      inData = DATA_W'(8'h0F + k * 41);
      chk(inReady == 1'b0, "R4 inReady", inReady, 0);
      tick();
      chk(dataOut == held, "R4 hold", dataOut, held);
    end
    chk(int'(actCount) == base, "R9 shut idle", actCount, base);

    // R5 shut-idle capture sequence
    inData = 8'hC7; inValid = 1'b1; outReady = 1'b0;
    #1;
    chk(inReady == 1'b0, "R5 not ready", inReady, 0);
    tick();
    chk(inReady == 1'b1, "R5 opening ready", inReady, 1);
    chk(outValid == 1'b0, "R5 not valid yet", outValid, 0);
    tick();
    inValid = 1'b0;
    chk(outValid == 1'b1, "R5 valid", outValid, 1);
    chk(dataOut == 8'hC7, "R5 data", dataOut, 8'hC7);
    // R8 request deferred while full
    modeReq = 1'b0;
    repeat (3) tick();
    chk(modeNow == 1'b1, "R8 deferred", modeNow, 1);
    outReady = 1'b1;
    tick();
    chk(int'(actCount) == base + 2, "R9 shut item", actCount, base + 2);
    chk(modeNow == 1'b1, "R8 drain edge", modeNow, 1);
    tick();
    chk(modeNow == 1'b0, "R8 after drain", modeNow, 0);

    // R6 streaming sweep over both policies and back-pressure patterns
    for (int m = 0; m < 2; m++) begin
      setMode(m[0]);
      for (int p = 0; p < 3; p++) begin
        stream(m, p);
        outReady = 1'b1;
        repeat (2) tick();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule